// File: doc/BRIEF.md
# Rotating-Parity Stripe Placement Mapper

This block turns a logical block index into its place in a five-column striped array that uses one parity block per stripe. Each stripe holds four data blocks and one parity block. Logical indices fill one stripe before they move on to the next. The parity block steps one column to the left on every stripe and wraps back to the highest column after five stripes. Inside each stripe, the data blocks take the columns that parity leaves free, lowest column first.

A request is one index qualified by a valid strobe. One clock later the block returns the stripe number, the column that holds the data block and the column that holds that stripe's parity, together with a registered valid flag. The block only computes addresses. It does no division: the stripe residue modulo the column count comes from folding the stripe number into fixed-width chunks. The column count is a parameter. At elaboration it is checked to be an odd value whose data-block count per stripe is a power of two.

The output register is a two-state machine. ST_EMPTY means no result was produced on the last edge, and ST_LOADED means a fresh result is on the outputs. The transition ST_EMPTY to ST_LOADED (load) and the transition ST_LOADED to ST_LOADED (reload) are taken when the input strobe is high. The transition ST_LOADED to ST_EMPTY (drain) and the transition ST_EMPTY to ST_EMPTY (idle) are taken when the strobe is low. Reset forces ST_EMPTY.

Top module: `raid5_place_map`

## Requirements
- R1: The stripe output equals the logical index divided by 4 (index bits 15:2).
- R2: The parity column equals 4 minus (stripe mod 5). Stripe 0 gives column 4, stripe 1 column 3, stripe 4 column 0, and stripe 5 gives column 4 again.
- R3: With offset = index mod 4 (index bits 1:0), the data column equals offset when offset is below the parity column and offset+1 otherwise, so it never equals the parity column. For example, index 7 maps to column 4.
- R4: The output valid flag is high in exactly the cycle after an edge that sampled the input strobe high, and low after an edge that sampled it low.
- R5: While the input strobe is low, the stripe and column outputs keep their last values, whatever the index input does.
- R6: After reset, the valid flag, stripe and both column outputs are all 0.
- R7: Across the four data blocks of any stripe, the data columns and the parity column together cover all five columns exactly once.
- R8: The mapping holds over the whole 16-bit index range, including index 65535 (stripe 16383, parity column 1, data column 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | Request strobe for blk_idx |
| blk_idx | input | 16 | Logical block index |
| map_valid | output | 1 | Result valid, one cycle after the request |
| map_stripe | output | 14 | Stripe number |
| map_data_col | output | 3 | Column that holds the data block |
| map_par_col | output | 3 | Column that holds the stripe's parity |

## Verification
The bench sends every 16-bit index back to back and computes each expected stripe and column by plain division and remainder. This catches folding errors that show up only for large stripe values, as well as the wrap of the rotation every five stripes. A short stretch of requests alternating with idle cycles separates the load, reload, drain and idle transitions and shows that the outputs hold while the strobe is low. Directed indices at the stripe-0 and stripe-1 boundaries, at stripe 5 and at 65535, together with a check that each stripe covers all five columns, pin down the skip over the parity column.

// File: rtl/raid5_map_pkg.sv
`timescale 1ns/1ps
package raid5_map_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } out_state_e;

    // smallest p with 2^p mod ncol == 1 (ncol odd)
    function automatic int fold_period(input int ncol);
        int r;
        int found;
        r = 1;
        found = 0;
        for (int p = 1; p <= 30; p++) begin
            r = (r * 2) % ncol;
            if (found == 0 && r == 1) found = p;
        end
        return (found == 0) ? 1 : found;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/raid5_stripe_mod.sv
`timescale 1ns/1ps
module raid5_stripe_mod
    import raid5_map_pkg::*;
#(
    parameter int IN_W  = 14,
    parameter int NCOL  = 5,
    parameter int RES_W = 3
) (
    input  logic [IN_W-1:0]  value,
    output logic [RES_W-1:0] residue
);
    localparam int P      = fold_period(NCOL);
    localparam int NCH    = ceil_div(IN_W, P);
    localparam int PAD_W  = NCH * P;
    localparam int SUM_W  = max_int($clog2(NCH * ((1 << P) - 1) + 1), P + 1);
    localparam int NCH2   = ceil_div(SUM_W, P);
    localparam int PAD2_W = NCH2 * P;
    localparam int NFOLD  = 3;
    localparam int SUB_N  = ceil_div(1 << (P + 1), NCOL) + 1;

    // one fold step: sum of P-bit chunks keeps the value modulo NCOL
    function automatic logic [SUM_W-1:0] fold_once(input logic [SUM_W-1:0] x);
        logic [PAD2_W-1:0] px;
        logic [SUM_W-1:0]  s;
        px = PAD2_W'(x);
        s  = '0;
        for (int c = 0; c < NCH2; c++) begin
            s = s + SUM_W'(px[c*P +: P]);
        end
        return s;
    endfunction

    logic [PAD_W-1:0] padded;
    logic [SUM_W-1:0] stage_v [0:NFOLD];

    assign padded = PAD_W'(value);

    always_comb begin
        stage_v[0] = '0;
        for (int c = 0; c < NCH; c++) begin
            stage_v[0] = stage_v[0] + SUM_W'(padded[c*P +: P]);
        end
    end

    for (genvar s = 0; s < NFOLD; s++) begin : g_fold
        assign stage_v[s+1] = fold_once(stage_v[s]);
    end

    always_comb begin
        logic [SUM_W-1:0] acc;
        acc = stage_v[NFOLD];
        for (int k = 0; k < SUB_N; k++) begin
            if (acc >= SUM_W'(NCOL)) acc = acc - SUM_W'(NCOL);
        end
        residue = RES_W'(acc);
    end

endmodule

// File: rtl/raid5_col_place.sv
`timescale 1ns/1ps
module raid5_col_place #(
    parameter int NCOL  = 5,
    parameter int OFS_W = 2,
    parameter int COL_W = 3
) (
    input  logic [COL_W-1:0] rot,
    input  logic [OFS_W-1:0] offset,
    output logic [COL_W-1:0] par_col,
    output logic [COL_W-1:0] data_col
);
    logic [COL_W-1:0] ofs_ext;

    assign ofs_ext = COL_W'(offset);

    always_comb begin
        par_col  = COL_W'(NCOL - 1) - rot;
        data_col = (ofs_ext < par_col) ? ofs_ext : ofs_ext + COL_W'(1);
    end

endmodule

// File: rtl/raid5_out_stage.sv
`timescale 1ns/1ps
module raid5_out_stage
    import raid5_map_pkg::*;
#(
    parameter int STRIPE_W = 14,
    parameter int COL_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [STRIPE_W-1:0] in_stripe,
    input  logic [COL_W-1:0]    in_data_col,
    input  logic [COL_W-1:0]    in_par_col,
    output logic                out_valid,
    output logic [STRIPE_W-1:0] out_stripe,
    output logic [COL_W-1:0]    out_data_col,
    output logic [COL_W-1:0]    out_par_col
);
    out_state_e state_q;
    out_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_stripe   <= '0;
            out_data_col <= '0;
            out_par_col  <= '0;
        end else if (in_valid) begin
            out_stripe   <= in_stripe;
            out_data_col <= in_data_col;
            out_par_col  <= in_par_col;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

    // R4
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_stripe) && $stable(out_data_col) && $stable(out_par_col)));

endmodule

// File: rtl/raid5_place_map.sv
`timescale 1ns/1ps
module raid5_place_map #(
    parameter int IDX_W = 16,
    parameter int NCOL  = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            blk_valid,
    input  logic [IDX_W-1:0]                blk_idx,
    output logic                            map_valid,
    output logic [IDX_W-$clog2(NCOL-1)-1:0] map_stripe,
    output logic [$clog2(NCOL)-1:0]         map_data_col,
    output logic [$clog2(NCOL)-1:0]         map_par_col
);
    localparam int DPS      = NCOL - 1;
    localparam int OFS_W    = $clog2(DPS);
    localparam int STRIPE_W = IDX_W - OFS_W;
    localparam int COL_W    = $clog2(NCOL);

    if (NCOL < 3 || (NCOL % 2) == 0 || ((DPS & (DPS - 1)) != 0)) begin : g_bad_ncol
        $error("column count must be odd with a power-of-two data block count");
    end

    logic [STRIPE_W-1:0] stripe;
    logic [OFS_W-1:0]    offset;
    logic [COL_W-1:0]    rot;
    logic [COL_W-1:0]    par_col;
    logic [COL_W-1:0]    data_col;

    assign stripe = blk_idx[IDX_W-1:OFS_W];
    assign offset = blk_idx[OFS_W-1:0];

    raid5_stripe_mod #(
        .IN_W  (STRIPE_W),
        .NCOL  (NCOL),
        .RES_W (COL_W)
    ) i_mod (
        .value   (stripe),
        .residue (rot)
    );

    raid5_col_place #(
        .NCOL  (NCOL),
        .OFS_W (OFS_W),
        .COL_W (COL_W)
    ) i_place (
        .rot      (rot),
        .offset   (offset),
        .par_col  (par_col),
        .data_col (data_col)
    );

    raid5_out_stage #(
        .STRIPE_W (STRIPE_W),
        .COL_W    (COL_W)
    ) i_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (blk_valid),
        .in_stripe    (stripe),
        .in_data_col  (data_col),
        .in_par_col   (par_col),
        .out_valid    (map_valid),
        .out_stripe   (map_stripe),
        .out_data_col (map_data_col),
        .out_par_col  (map_par_col)
    );

    // R2
    par_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> (map_par_col < COL_W'(NCOL)));
    // R2
    par_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && $past(map_valid) && $past(map_stripe) != '1
         && map_stripe == $past(map_stripe) + STRIPE_W'(1))
        |-> (map_par_col == (($past(map_par_col) == '0) ? COL_W'(NCOL - 1)
                                                        : $past(map_par_col) - COL_W'(1))));
    // R3
    col_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_valid |-> (map_data_col != map_par_col && map_data_col < COL_W'(NCOL)));
    // R1
    stripe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |=> (map_stripe == $past(blk_idx[IDX_W-1:OFS_W])));

endmodule

// File: tb/test_raid5_place_map.sv
`timescale 1ns/1ps
module test_raid5_place_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_valid = 1'b0;
    logic [15:0] blk_idx = '0;
    logic        map_valid;
    logic [13:0] map_stripe;
    logic [2:0]  map_data_col;
    logic [2:0]  map_par_col;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    raid5_place_map i_raid5_place_map (
        .clk          (clk),
        .rst_n        (rst_n),
        .blk_valid    (blk_valid),
        .blk_idx      (blk_idx),
        .map_valid    (map_valid),
        .map_stripe   (map_stripe),
        .map_data_col (map_data_col),
        .map_par_col  (map_par_col)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int e_stripe(input int i);
        return i / 4;
    endfunction
    function automatic int e_par(input int i);
        return 4 - ((i / 4) % 5);
    endfunction
    function automatic int e_col(input int i);
        int off;
        off = i % 4;
        return (off < e_par(i)) ? off : off + 1;
    endfunction

    // drive at a negedge, sample at the following negedge
    task automatic map_one(input int i);
        blk_idx   = 16'(i);
        blk_valid = 1'b1;
        @(negedge clk);
        chk("R4 valid", int'(map_valid), 1);
        chk("R1 stripe", int'(map_stripe), e_stripe(i));
        chk("R2 parity", int'(map_par_col), e_par(i));
        chk("R3 data col", int'(map_data_col), e_col(i));
    endtask

    task automatic hold_check(input int last);
        chk("R4 idle valid", int'(map_valid), 0);
        chk("R5 hold stripe", int'(map_stripe), e_stripe(last));
        chk("R5 hold data col", int'(map_data_col), e_col(last));
        chk("R5 hold parity", int'(map_par_col), e_par(last));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cover_mask;
        repeat (3) @(negedge clk);
        chk("R6 reset valid", int'(map_valid), 0);
        chk("R6 reset stripe", int'(map_stripe), 0);
        chk("R6 reset data col", int'(map_data_col), 0);
        chk("R6 reset parity", int'(map_par_col), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners: stripe 0, stripe 1 skip, stripe 5 wrap, top index
        for (int i = 0; i < 8; i++) map_one(i);
        chk("R3 index 7 column", int'(map_data_col), 4);
        map_one(20);
        chk("R2 stripe 5 parity", int'(map_par_col), 4);
        map_one(65535);
        chk("R8 top stripe", int'(map_stripe), 16383);
        chk("R8 top parity", int'(map_par_col), 1);
        chk("R8 top data col", int'(map_data_col), 4);

        // full sweep, back to back; R7 coverage per stripe for the first stripes
        cover_mask = 0;
        for (int i = 0; i < 65536; i++) begin
            map_one(i);
            if (i < 80) begin
                cover_mask = cover_mask | (1 << map_data_col);
                if (i % 4 == 3) begin
                    chk("R7 data columns distinct", $countones(5'(cover_mask)), 4);
                    chk("R7 stripe covers all columns", cover_mask | (1 << map_par_col), 31);
                    cover_mask = 0;
                end
            end
        end

        // idle: outputs hold, index changes ignored
        blk_valid = 1'b0;
        @(negedge clk);
        hold_check(65535);
        blk_idx = 16'd5;
        repeat (3) @(negedge clk);
        hold_check(65535);

        // alternating requests and idle cycles
        for (int i = 100; i < 140; i++) begin
            map_one(i * 37);
            blk_valid = 1'b0;
            blk_idx   = 16'(i);
            @(negedge clk);
            hold_check(i * 37);
        end

        // reset during operation
        map_one(4097);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R6 rerun valid", int'(map_valid), 0);
        chk("R6 rerun stripe", int'(map_stripe), 0);
        chk("R6 rerun data col", int'(map_data_col), 0);
        chk("R6 rerun parity", int'(map_par_col), 0);
        rst_n = 1'b1;
        blk_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule